// File: doc/BRIEF.md
# Dual-Select SPI Slave Front End

This block is an SPI slave that carries two logical ports over one shared clock, data-in and data-out line set. Each port has its own active-low select. The configuration port gives the host read and write access to a small register file. Slot 0 of that file is a read-only status byte. The data port moves whole bytes into a receive FIFO and out of a transmit FIFO. Both FIFOs are reached from the chip side through simple push/pop ports.

All external SPI pins are brought into the system clock through two-flop synchronizers, and SCK edges are detected there. The system clock must run at least 8 times faster than the fastest SCK. The data-out pin is presented as a value plus an output enable, for a pad tri-state buffer.

Top module: `dual_port_spi_slave`

## Requirements
- R1: Port selection follows a fixed priority. A low `cfg_cs_n_i` selects the configuration port whatever `dat_cs_n_i` is. The data port is selected only when `dat_cs_n_i` is low and `cfg_cs_n_i` is high. While the configuration port is selected, the data FIFOs are untouched.
- R2: `miso_oe_o` is high exactly when some port is selected, three system clocks after the select inputs change. With both selects high it is low.
- R3: SPI mode 0, most significant bit first. MOSI is sampled on rising SCK. MISO changes only after a falling SCK edge or at a change of selection. The first bit of a byte is on MISO before its first rising edge.
- R4: A configuration transaction is two bytes. In the command byte, bit 7 = 1 means write and bit 7 = 0 means read; bits 4:0 are the register address and bits 6:5 are ignored. MISO carries 0x00 during the command byte. During the second byte MISO carries the addressed register's current value. On a write, the second byte is stored when its eighth bit arrives.
- R5: After reset, register i (1 to NREG-1) holds i*0x11. `cfg_regs_o` shows register i at bits [8i+7:8i], and slot 0 reads as 0.
- R6: Address 0 is the status register. It reads as {`underrun_o`, `status_i[6:0]`}, and writes to it change nothing.
- R7: Addresses NREG to 31 read as 0x00, and writes to them change nothing.
- R8: Several configuration transactions may follow one another within a single selection. The command/data phase restarts at each new selection.
- R9: On the data port, every completed received byte is pushed into the receive FIFO. `rx_data_o` shows the oldest entry while `rx_empty_o` is low, and `rx_pop_i` removes it.
- R10: On the data port, each byte sends the head of the transmit FIFO. The entry is removed on the byte's first rising SCK edge. If the FIFO was empty when the byte began, the byte is 0x00 and `underrun_o` goes high and stays high until reset.
- R11: If the selection ends before 8 bits, the partial received byte is discarded and the bit count restarts. A transmit entry whose first bit was clocked counts as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| cfg_cs_n_i | input | 1 | Configuration port select, active low |
| dat_cs_n_i | input | 1 | Data port select, active low |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| status_i | input | 8 | Live status bits; bit 7 is replaced by the underrun flag |
| cfg_regs_o | output | NREG*8 | Register file contents |
| tx_push_i | input | 1 | Push into the transmit FIFO |
| tx_data_i | input | 8 | Byte to push |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_pop_i | input | 1 | Pop from the receive FIFO |
| rx_data_o | output | 8 | Oldest received byte |
| rx_empty_o | output | 1 | Receive FIFO empty |
| underrun_o | output | 1 | Sticky transmit underrun flag |

## Verification
The two functions that can fall in the same cycle are the selection of the configuration port and the selection of the data port. Both selects are pulled low on the same clock, and a register write is then carried out. The result is judged three ways: the write lands in the register file, the receive FIFO stays empty, and the transmit entries queued beforehand come out intact on the next data-port transfer. The selection, MISO-enable and shift behaviour is also compared against a behavioural model on every clock and every byte.

// File: rtl/dps_pkg.sv
package dps_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_CFG  = 2'd1,
        PORT_DAT  = 2'd2
    } port_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [1:0]        spare;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // configuration select has priority over the data select
    function automatic port_e pick_port(logic cfg_n, logic dat_n);
        if (!cfg_n) return PORT_CFG;
        if (!dat_n) return PORT_DAT;
        return PORT_NONE;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(int unsigned idx);
        return BYTE_W'(idx * 17);
    endfunction
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk) begin
            if (rst) stage <= {2{RST_VAL[g]}};
            else     stage <= {stage[0], async_i[g]};
        end
        assign sync_o[g] = stage[1];
    end
endmodule

// File: rtl/dps_shifter.sv
module dps_shifter
    import dps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_e             port_now,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] load_val,
    output port_e             port_q,
    output logic              sel_change,
    output logic              sck_fall,
    output logic              load_stb,
    output logic              first_bit,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_d;
    logic              sck_rise;
    logic              active;
    logic              step;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign sck_rise   = sck_s & ~sck_d;
    assign sck_fall   = ~sck_s & sck_d;
    assign sel_change = (port_now != port_q);
    assign active     = (port_now != PORT_NONE);
    assign step       = sck_rise && active && !sel_change;
    assign first_bit  = step && (cnt == '0);
    assign byte_done  = step && (cnt == CNT_W'(BYTE_W - 1));
    assign load_stb   = active && (sel_change || (sck_fall && cnt == '0));
    assign rx_byte    = {rx_sh[BYTE_W-2:0], mosi_s};
    assign miso       = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            port_q <= PORT_NONE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
        end else begin
            sck_d  <= sck_s;
            port_q <= port_now;
            if (sel_change || !active) cnt <= '0;
            else if (step)             cnt <= cnt + 1'b1;
            if (step) rx_sh <= rx_byte;
            if (load_stb)
                tx_sh <= load_val;
            else if (sck_fall && active && !sel_change)
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/dps_fifo.sv
module dps_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/dps_regfile.sv
module dps_regfile
    import dps_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] status_val,
    output logic [BYTE_W-1:0] rd_data,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] slot [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_status
            assign slot[i] = '0;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= reg_default(i);
                else if (wr_en && wr_addr == ADDR_W'(i))
                    slot[i] <= wr_data;
            end
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = slot[i];
    end

    always_comb begin
        if (rd_addr == '0)
            rd_data = status_val;
        else if (int'(rd_addr) < NREG)
            rd_data = slot[rd_addr];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/dual_port_spi_slave.sv
module dual_port_spi_slave
    import dps_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sck_i,
    input  logic                   mosi_i,
    input  logic                   cfg_cs_n_i,
    input  logic                   dat_cs_n_i,
    output logic                   miso_o,
    output logic                   miso_oe_o,
    input  logic [7:0]             status_i,
    output logic [NREG*8-1:0]      cfg_regs_o,
    input  logic                   tx_push_i,
    input  logic [7:0]             tx_data_i,
    output logic                   tx_full_o,
    input  logic                   rx_pop_i,
    output logic [7:0]             rx_data_o,
    output logic                   rx_empty_o,
    output logic                   underrun_o
);
    logic [3:0]        pins_s;
    logic              sck_s, mosi_s, cfg_s, dat_s;
    port_e             port_now, port_q;
    logic              sel_change, sck_fall, load_stb, first_bit, byte_done;
    logic [BYTE_W-1:0] rx_byte, load_val, rd_data, tx_head;
    logic              sh_miso, tx_empty;
    phase_e            phase;
    cmd_t              cmd;
    logic              tx_live, underrun;
    logic              wr_en, tx_pop, rx_push;
    logic [ADDR_W-1:0] wr_addr;

    dps_sync #(.W(4), .RST_VAL(4'b0011)) sync_i (
        .clk(clk), .rst(rst),
        .async_i({sck_i, mosi_i, cfg_cs_n_i, dat_cs_n_i}),
        .sync_o(pins_s)
    );
    assign {sck_s, mosi_s, cfg_s, dat_s} = pins_s;
    assign port_now = pick_port(cfg_s, dat_s);

    dps_shifter shift_i (
        .clk(clk), .rst(rst), .port_now(port_now), .sck_s(sck_s),
        .mosi_s(mosi_s), .load_val(load_val), .port_q(port_q),
        .sel_change(sel_change), .sck_fall(sck_fall), .load_stb(load_stb),
        .first_bit(first_bit), .byte_done(byte_done), .rx_byte(rx_byte),
        .miso(sh_miso)
    );

    // configuration protocol and data-port bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            cmd      <= '0;
            tx_live  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (sel_change)
                phase <= PH_CMD;
            else if (byte_done && port_q == PORT_CFG) begin
                if (phase == PH_CMD) begin
                    cmd   <= cmd_t'(rx_byte);
                    phase <= PH_DATA;
                end else begin
                    phase <= PH_CMD;
                end
            end
            if (load_stb && port_now == PORT_DAT)
                tx_live <= !tx_empty;
            if (first_bit && port_q == PORT_DAT && !tx_live)
                underrun <= 1'b1;
        end
    end

    assign wr_en   = byte_done && port_q == PORT_CFG && phase == PH_DATA && cmd.wr;
    assign wr_addr = cmd.addr;
    assign tx_pop  = first_bit && port_q == PORT_DAT && tx_live;
    assign rx_push = byte_done && port_q == PORT_DAT;

    always_comb begin
        unique case (port_now)
            PORT_CFG: load_val = (phase == PH_DATA && !sel_change) ? rd_data : '0;
            PORT_DAT: load_val = tx_empty ? '0 : tx_head;
            default:  load_val = '0;
        endcase
    end

    dps_regfile #(.NREG(NREG)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(rx_byte), .rd_addr(cmd.addr),
        .status_val({underrun, status_i[6:0]}),
        .rd_data(rd_data), .regs_flat(cfg_regs_o)
    );

    dps_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) txq_i (
        .clk(clk), .rst(rst), .push(tx_push_i), .wdata(tx_data_i),
        .pop(tx_pop), .head(tx_head), .full(tx_full_o), .empty(tx_empty)
    );

    dps_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) rxq_i (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop_i), .head(rx_data_o), .full(), .empty(rx_empty_o)
    );

    assign miso_oe_o  = (port_q != PORT_NONE);
    assign miso_o     = miso_oe_o & sh_miso;
    assign underrun_o = underrun;
endmodule

// File: rtl/dps_checker.sv
module dps_checker
    import dps_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_cs_n_i,
    input logic              dat_cs_n_i,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              underrun_o,
    input logic [NREG*8-1:0] cfg_regs_o,
    input port_e             port_q,
    input logic              sck_fall,
    input logic              sel_change,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rx_push
);
    a_r1_cfg_wins: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_cs_n_i, 3) |-> port_q == PORT_CFG);

    a_r1_dat_alone: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_cs_n_i, 3) && !$past(dat_cs_n_i, 3)) |-> port_q == PORT_DAT);

    a_r2_oe_follows_selects: assert property (@(posedge clk) disable iff (rst)
        miso_oe_o == !($past(cfg_cs_n_i, 3) && $past(dat_cs_n_i, 3)));

    a_r3_miso_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
        (miso_oe_o && $past(miso_oe_o) && miso_o != $past(miso_o))
            |-> $past(sck_fall || sel_change));

    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> $stable(cfg_regs_o));

    a_r7_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) >= NREG) |=> $stable(cfg_regs_o));

    a_r9_rx_only_from_data_port: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> port_q == PORT_DAT);

    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> underrun_o);
endmodule

bind dual_port_spi_slave dps_checker #(.NREG(NREG)) chk_i (
    .clk(clk), .rst(rst), .cfg_cs_n_i(cfg_cs_n_i), .dat_cs_n_i(dat_cs_n_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .underrun_o(underrun_o),
    .cfg_regs_o(cfg_regs_o), .port_q(port_q), .sck_fall(sck_fall),
    .sel_change(sel_change), .wr_en(wr_en), .wr_addr(wr_addr),
    .rx_push(rx_push)
);

// File: tb/dual_port_spi_slave_tb_top.sv
module dual_port_spi_slave_tb_top;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, mosi = 1'b0, cfg_n = 1'b1, dat_n = 1'b1;
    logic miso, miso_oe;
    logic [7:0] status = 8'h00;
    logic [NREG*8-1:0] regs;
    logic tx_push = 1'b0, tx_full, rx_pop = 1'b0, rx_empty, und;
    logic [7:0] tx_data = 8'h00, rx_data;

    always #5 clk = ~clk;

    dual_port_spi_slave #(.NREG(NREG)) dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi),
        .cfg_cs_n_i(cfg_n), .dat_cs_n_i(dat_n), .miso_o(miso),
        .miso_oe_o(miso_oe), .status_i(status), .cfg_regs_o(regs),
        .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
        .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
        .underrun_o(und)
    );

    int checks = 0, errors = 0;
    logic [7:0] m_regs [NREG];
    logic [7:0] m_txq [$];
    logic [7:0] m_rxq [$];
    bit m_und = 1'b0;
    bit finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference for output enable: selects seen three clocks back
    logic [1:0] h0 = 2'b11, h1 = 2'b11, h2 = 2'b11;
    always @(posedge clk) begin
        h2 <= h1; h1 <= h0; h0 <= {cfg_n, dat_n};
    end
    always @(negedge clk) begin
        if (!rst) chk("R2 oe per clock", 32'(miso_oe), 32'(!(h2[1] && h2[0])));
    end

    task automatic pause(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] out, output logic [7:0] got, input int nbits);
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            mosi = out[7-i];
            pause(4);
            got = {got[6:0], miso};
            sck = 1'b1;
            pause(4);
            sck = 1'b0;
        end
    endtask

    task automatic deselect();
        pause(4);
        cfg_n = 1'b1;
        dat_n = 1'b1;
        pause(6);
    endtask

    task automatic cfg_xfer(input bit wr, input int a, input logic [7:0] d, input string tag);
        logic [7:0] got, exp;
        spi_byte({wr, 2'b00, 5'(a)}, got, 8);
        chk({tag, " cmd byte"}, 32'(got), 32'h0);
        if (a == 0)         exp = {m_und, status[6:0]};
        else if (a < NREG)  exp = m_regs[a];
        else                exp = 8'h00;
        spi_byte(d, got, 8);
        chk({tag, " data byte"}, 32'(got), 32'(exp));
        if (wr && a != 0 && a < NREG) m_regs[a] = d;
    endtask

    task automatic dat_xfer(input logic [7:0] d, input string tag);
        logic [7:0] got, exp;
        if (m_txq.size() > 0) exp = m_txq.pop_front();
        else begin exp = 8'h00; m_und = 1'b1; end
        spi_byte(d, got, 8);
        chk(tag, 32'(got), 32'(exp));
        m_rxq.push_back(d);
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_data = d; tx_push = 1'b1;
        pause(1);
        tx_push = 1'b0;
        m_txq.push_back(d);
    endtask

    task automatic drain_rx(input string tag);
        while (m_rxq.size() > 0) begin
            chk({tag, " rx not empty"}, 32'(rx_empty), 32'h0);
            chk({tag, " rx byte"}, 32'(rx_data), 32'(m_rxq.pop_front()));
            rx_pop = 1'b1;
            pause(1);
            rx_pop = 1'b0;
        end
        chk({tag, " rx drained"}, 32'(rx_empty), 32'h1);
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " slot0"}, 32'(regs[7:0]), 32'h0);
        for (int i = 1; i < NREG; i++)
            chk({tag, " reg"}, 32'(regs[i*8 +: 8]), 32'(m_regs[i]));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'(i * 17);
        pause(5);
        rst = 1'b0;
        pause(2);
        // reset state
        chk("R2 reset oe", 32'(miso_oe), 32'h0);
        chk("R10 reset underrun", 32'(und), 32'h0);
        chk("R9 reset rx empty", 32'(rx_empty), 32'h1);
        check_regs("R5 defaults");

        // default read, write, readback in one selection
        cfg_n = 1'b0; pause(5);
        cfg_xfer(1'b0, 5, 8'hAA, "R5 read default");
        cfg_xfer(1'b1, 3, 8'h5C, "R4 write");
        cfg_xfer(1'b0, 3, 8'h00, "R8 back-to-back readback");
        deselect();
        check_regs("R4 after write");

        // status register
        status = 8'h2B;
        cfg_n = 1'b0; pause(5);
        cfg_xfer(1'b1, 0, 8'hFF, "R6 status write");
        cfg_xfer(1'b0, 0, 8'h00, "R6 status read");
        deselect();
        check_regs("R6 regs untouched");

        // addresses beyond the file
        cfg_n = 1'b0; pause(5);
        cfg_xfer(1'b1, 20, 8'h99, "R7 write high");
        cfg_xfer(1'b1, NREG, 8'h66, "R7 write first absent");
        cfg_xfer(1'b0, 20, 8'h00, "R7 read high");
        deselect();
        check_regs("R7 regs untouched");

        // both selects low together: config wins
        push_tx(8'hC3);
        push_tx(8'h3C);
        cfg_n = 1'b0; dat_n = 1'b0; pause(5);
        cfg_xfer(1'b1, 2, 8'h42, "R1 both low");
        deselect();
        check_regs("R1 write landed");
        chk("R1 rx untouched", 32'(rx_empty), 32'h1);

        // data port: two queued bytes then an underrun
        dat_n = 1'b0; pause(5);
        dat_xfer(8'h11, "R3 data msb first");
        dat_xfer(8'h22, "R10 second tx");
        dat_xfer(8'h33, "R10 empty sends zero");
        deselect();
        chk("R10 underrun set", 32'(und), 32'h1);
        drain_rx("R9");

        // status shows the flag
        cfg_n = 1'b0; pause(5);
        cfg_xfer(1'b0, 0, 8'h00, "R6 status with underrun");
        deselect();

        // aborted byte
        push_tx(8'h5A);
        push_tx(8'hA5);
        dat_n = 1'b0; pause(5);
        spi_byte(8'hF0, got, 4);
        chk("R11 partial tx bits", 32'(got[3:0]), 32'h5);
        void'(m_txq.pop_front());
        deselect();
        chk("R11 partial discarded", 32'(rx_empty), 32'h1);
        dat_n = 1'b0; pause(5);
        dat_xfer(8'h81, "R11 realigned byte");
        deselect();
        drain_rx("R11");
        chk("R10 underrun still set", 32'(und), 32'h1);

        pause(5);
        finish_run();
    end
endmodule